// File: doc/BRIEF.md
# Frame Rate Down-Converter Write Controller

This block sits between a streaming video source and the write port of a frame buffer. Each pixel arrives as a 24-bit RGB word with a valid strobe and a flag that marks the first pixel of a frame. The block keeps one frame out of every four and drops the other three. A 60 frames-per-second input therefore reaches memory at 15 frames per second. The block emits one write (address, data, strobe) for each kept pixel.

After reset the block has no idea where a frame begins. It discards everything until it sees a flagged first pixel. It writes that frame, and on the same step it sends a one-cycle reset pulse to the paired read controller. The frame buffer is a ping-pong pair of regions. When a kept frame is complete, the block works out its next region and holds a continue signal toward the reader. It waits there until the reader reports that it has finished its own frame. At that handshake both sides exchange regions, and the reader is shown the base of the region that was just filled.

Top module: `frame_decim_writer`

## Requirements
- R1: After reset wrEn, wrContinue and rdReset are 0, and readBase equals BASE1 (writing starts in the BASE0 region).
- R2: After reset, valid pixels are dropped (no write) until a valid pixel with pixFirst=1 arrives. That pixel is written to address BASE0.
- R3: rdReset is high for exactly one cycle: the same cycle in which the write of the aligning pixel appears on the outputs.
- R4: In a kept frame, the k-th valid pixel (k from 0) appears one cycle after it is accepted, with wrEn=1, wrAddr equal to the region base plus k, and wrData equal to the pixel. Cycles with pixValid=0 produce no write.
- R5: After FRAME_PIXELS pixels of a kept frame have been written, further pixels are dropped. wrContinue is high from the cycle in which the last write appears until the cycle after rdFinish is sampled high.
- R6: When rdFinish is sampled high while wrContinue is high, three things happen on the next cycle: wrContinue falls, readBase shows the base of the region just filled, and the next kept frame is written to the other region.
- R7: A frame start is a valid pixel with pixFirst=1. Frame starts are counted modulo 4, and the aligned frame is index 0. After a completed handshake, starts 1, 2 and 3 are dropped and start 4 is written.
- R8: If the start of a kept slot (index a multiple of 4) arrives while wrContinue is still high, that whole frame is dropped. The count still advances, so the next frame written is four starts later.
- R9: A pixFirst flag that arrives inside a kept frame before it is complete is treated as an ordinary pixel. It is written and is not counted as a frame start.
- R10: rdFinish has no effect while wrContinue is low: readBase and the region used for writing stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| pixData | input | DATA_W | Incoming RGB pixel |
| pixValid | input | 1 | Pixel present this cycle |
| pixFirst | input | 1 | Pixel is the first of a frame |
| rdFinish | input | 1 | Reader has finished its frame |
| wrAddr | output | ADDR_W | Frame buffer write address |
| wrData | output | DATA_W | Frame buffer write data |
| wrEn | output | 1 | Write strobe |
| wrContinue | output | 1 | Frame done, waiting for the reader |
| rdReset | output | 1 | One-cycle reset pulse to the reader |
| readBase | output | ADDR_W | Base of the region the reader should use |

## Verification
A wrong frame count or a wrong alignment state shows up at the ports as whole frames written in the wrong slot. That is caught as an unexpected write, or a missing one, at the first pixel of the wrong frame. A wrong address counter or pixel counter corrupts wrAddr within one pixel, or lets writes run past the frame end, where the scoreboard finds an extra item. A broken handshake or region toggle appears the cycle after rdFinish, in wrContinue and readBase, and again in the base of the next kept frame.

// File: rtl/fdw_pkg.sv
package fdw_pkg;

  typedef enum logic [1:0] {
    ST_ALIGN = 2'd0,
    ST_WRITE = 2'd1,
    ST_SYNC  = 2'd2,
    ST_SKIP  = 2'd3
  } wrState_t;

  typedef struct packed {
    logic write;
    logic restart;
    logic swap;
  } ctrlStrobe_t;

endpackage

// File: rtl/fdw_ctrl.sv
module fdw_ctrl
  import fdw_pkg::*;
#(
  parameter int KEEP_RATIO = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        pixValid,
  input  logic        pixFirst,
  input  logic        rdFinish,
  input  logic        lastPix,
  output ctrlStrobe_t strobe,
  output logic        wrContinue,
  output logic        rdReset
);

  localparam int CNT_W = (KEEP_RATIO > 2) ? $clog2(KEEP_RATIO) : 1;
  localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(KEEP_RATIO - 1);

  wrState_t         state, stateNext;
  logic [CNT_W-1:0] frameCnt;
  logic             startSeen;
  logic             keepHit;

  assign startSeen = pixValid && pixFirst;
  assign keepHit   = startSeen && (frameCnt == LAST_SLOT);

  always_comb begin
    strobe.write   = 1'b0;
    strobe.restart = 1'b0;
    strobe.swap    = 1'b0;
    case (state)
      ST_ALIGN: begin
        strobe.write   = startSeen;
        strobe.restart = startSeen;
      end
      ST_WRITE: strobe.write = pixValid;
      ST_SKIP: begin
        strobe.write   = keepHit;
        strobe.restart = keepHit;
      end
      ST_SYNC: strobe.swap = rdFinish;
      default: ;
    endcase
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_ALIGN: if (startSeen) stateNext = ST_WRITE;
      ST_WRITE: if (pixValid && lastPix) stateNext = ST_SYNC;
      ST_SYNC:  if (rdFinish) stateNext = ST_SKIP;
      ST_SKIP:  if (keepHit) stateNext = ST_WRITE;
      default:  stateNext = ST_ALIGN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_ALIGN;
      frameCnt <= '0;
      rdReset  <= 1'b0;
    end else begin
      state   <= stateNext;
      rdReset <= (state == ST_ALIGN) && startSeen;
      if (state == ST_ALIGN) begin
        if (startSeen) frameCnt <= '0;
      end else if ((state == ST_SYNC || state == ST_SKIP) && startSeen) begin
        frameCnt <= (frameCnt == LAST_SLOT) ? '0 : frameCnt + 1'b1;
      end
    end
  end

  assign wrContinue = (state == ST_SYNC);

  // R3: the reader reset pulse only follows an alignment step
  a_r3_reset_after_align: assert property (@(posedge clk) disable iff (!rstN)
    rdReset |-> $past(state == ST_ALIGN));

  // R7: writes that continue a frame only happen in slot zero
  a_r7_write_in_slot: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.write && !strobe.restart) |-> (frameCnt == '0));

  // R6: the continue signal is only released by the reader finishing
  a_r6_continue_release: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wrContinue) |-> $past(rdFinish));

  // R5: no writes are requested while waiting on the reader
  a_r5_no_write_waiting: assert property (@(posedge clk) disable iff (!rstN)
    wrContinue |-> !strobe.write);

endmodule

// File: rtl/fdw_datapath.sv
module fdw_datapath
  import fdw_pkg::*;
#(
  parameter int                DATA_W       = 24,
  parameter int                ADDR_W       = 20,
  parameter int                FRAME_PIXELS = 420000,
  parameter logic [ADDR_W-1:0] BASE0        = '0,
  parameter logic [ADDR_W-1:0] BASE1        = 20'h80000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] pixData,
  input  ctrlStrobe_t       strobe,
  output logic              lastPix,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              wrEn,
  output logic [ADDR_W-1:0] readBase
);

  localparam int CNT_W = $clog2(FRAME_PIXELS + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(FRAME_PIXELS - 1);

  logic              curSel;
  logic [ADDR_W-1:0] activeBase;
  logic [ADDR_W-1:0] addrCnt;
  logic [ADDR_W-1:0] addrSel;
  logic [CNT_W-1:0]  pixCnt;

  assign activeBase = curSel ? BASE1 : BASE0;
  assign addrSel    = strobe.restart ? activeBase : addrCnt;
  assign lastPix    = (pixCnt == LAST_CNT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curSel   <= 1'b0;
      readBase <= BASE1;
      addrCnt  <= BASE0;
      pixCnt   <= '0;
      wrEn     <= 1'b0;
      wrAddr   <= '0;
      wrData   <= '0;
    end else begin
      wrEn <= strobe.write;
      if (strobe.write) begin
        wrData  <= pixData;
        wrAddr  <= addrSel;
        addrCnt <= addrSel + 1'b1;
        pixCnt  <= strobe.restart ? CNT_W'(1) : pixCnt + 1'b1;
      end
      if (strobe.swap) begin
        readBase <= activeBase;
        curSel   <= ~curSel;
      end
    end
  end

  // R4: every write lands inside the active region
  a_r4_addr_in_frame: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> ((wrAddr - activeBase) < ADDR_W'(FRAME_PIXELS)));

  // R6: the reader never sees the region being filled
  a_r6_bases_differ: assert property (@(posedge clk) disable iff (!rstN)
    readBase != activeBase);

  // R10: readBase only moves on a handshake
  a_r10_base_on_swap: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(readBase) |-> $past(strobe.swap));

endmodule

// File: rtl/frame_decim_writer.sv
module frame_decim_writer
  import fdw_pkg::*;
#(
  parameter int                DATA_W       = 24,
  parameter int                ADDR_W       = 20,
  parameter int                FRAME_PIXELS = 420000,
  parameter int                KEEP_RATIO   = 4,
  parameter logic [ADDR_W-1:0] BASE0        = '0,
  parameter logic [ADDR_W-1:0] BASE1        = 20'h80000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] pixData,
  input  logic              pixValid,
  input  logic              pixFirst,
  input  logic              rdFinish,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              wrEn,
  output logic              wrContinue,
  output logic              rdReset,
  output logic [ADDR_W-1:0] readBase
);

  ctrlStrobe_t strobe;
  logic        lastPix;

  fdw_ctrl #(
    .KEEP_RATIO(KEEP_RATIO)
  ) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .pixValid  (pixValid),
    .pixFirst  (pixFirst),
    .rdFinish  (rdFinish),
    .lastPix   (lastPix),
    .strobe    (strobe),
    .wrContinue(wrContinue),
    .rdReset   (rdReset)
  );

  fdw_datapath #(
    .DATA_W      (DATA_W),
    .ADDR_W      (ADDR_W),
    .FRAME_PIXELS(FRAME_PIXELS),
    .BASE0       (BASE0),
    .BASE1       (BASE1)
  ) uPath (
    .clk     (clk),
    .rstN    (rstN),
    .pixData (pixData),
    .strobe  (strobe),
    .lastPix (lastPix),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .wrEn    (wrEn),
    .readBase(readBase)
  );

endmodule

// File: tb/tb_frame_decim_writer.sv
module tb_frame_decim_writer;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 24;
  localparam int ADDR_W = 12;
  localparam int FRAME_PIXELS = 6;
  localparam logic [ADDR_W-1:0] B0 = 12'h100;
  localparam logic [ADDR_W-1:0] B1 = 12'h200;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [DATA_W-1:0] pixData = '0;
  logic              pixValid = 1'b0;
  logic              pixFirst = 1'b0;
  logic              rdFinish = 1'b0;
  logic [ADDR_W-1:0] wrAddr;
  logic [DATA_W-1:0] wrData;
  logic              wrEn;
  logic              wrContinue;
  logic              rdReset;
  logic [ADDR_W-1:0] readBase;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  logic [ADDR_W+DATA_W-1:0] expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_decim_writer #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .FRAME_PIXELS(FRAME_PIXELS),
    .KEEP_RATIO(4), .BASE0(B0), .BASE1(B1)
  ) dut (
    .clk(clk), .rstN(rstN), .pixData(pixData), .pixValid(pixValid),
    .pixFirst(pixFirst), .rdFinish(rdFinish), .wrAddr(wrAddr), .wrData(wrData),
    .wrEn(wrEn), .wrContinue(wrContinue), .rdReset(rdReset), .readBase(readBase)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: R4 ordering, address and data of every write
  always @(negedge clk) begin
    if (rstN && wrEn) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R4/R7/R8 unexpected write addr", 32'(wrAddr), 32'hFFFF_FFFF);
      end else begin
        logic [ADDR_W+DATA_W-1:0] e;
        e = expQ.pop_front();
        check(wrAddr == e[ADDR_W+DATA_W-1:DATA_W], "R4 write address", 32'(wrAddr), 32'(e[ADDR_W+DATA_W-1:DATA_W]));
        check(wrData == e[DATA_W-1:0], "R4 write data", 32'(wrData), 32'(e[DATA_W-1:0]));
      end
    end
  end

  task automatic junk(input int n);
    for (int i = 0; i < n; i++) begin
      pixData = 24'hEE0000 + 24'(i);
      pixValid = 1'b1;
      pixFirst = 1'b0;
      @(posedge clk); #1;
      pixValid = 1'b0;
    end
  endtask

  task automatic sendFrame(input int tag, input bit keep, input logic [ADDR_W-1:0] base,
                           input int midFirst, input bit expRst);
    for (int i = 0; i < FRAME_PIXELS; i++) begin
      pixData  = {tag[7:0], 16'(i)};
      pixValid = 1'b1;
      pixFirst = (i == 0) || (i == midFirst);
      if (keep) expQ.push_back({base + ADDR_W'(i), pixData});
      @(posedge clk); #1;
      pixValid = 1'b0;
      pixFirst = 1'b0;
      if (i == 0) begin
        @(negedge clk);
        check(rdReset == expRst, "R3 rdReset pulse", 32'(rdReset), 32'(expRst));
      end
      if (i % 2 == 1) begin
        @(posedge clk); #1;
      end
    end
  endtask

  task automatic handshake(input logic [ADDR_W-1:0] expBase, input string tag);
    rdFinish = 1'b1;
    @(posedge clk); #1;
    rdFinish = 1'b0;
    @(negedge clk);
    check(wrContinue == 1'b0, {tag, " continue released"}, 32'(wrContinue), 32'h0);
    check(readBase == expBase, {tag, " readBase"}, 32'(readBase), 32'(expBase));
  endtask

  task automatic expectWaiting(input string tag);
    @(negedge clk);
    check(wrContinue == 1'b1, tag, 32'(wrContinue), 32'h1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(wrEn == 1'b0, "R1 wrEn", 32'(wrEn), 32'h0);
    check(wrContinue == 1'b0, "R1 wrContinue", 32'(wrContinue), 32'h0);
    check(rdReset == 1'b0, "R1 rdReset", 32'(rdReset), 32'h0);
    check(readBase == B1, "R1 readBase", 32'(readBase), 32'(B1));

    // R2: unaligned pixels dropped
    junk(3);
    @(negedge clk);
    check(wrEn == 1'b0, "R2 no write before alignment", 32'(wrEn), 32'h0);

    // R2/R3/R4: aligned frame 0 kept at B0
    sendFrame(0, 1'b1, B0, -1, 1'b1);
    // R5: extra pixels after frame end dropped while waiting
    junk(2);
    expectWaiting("R5 continue after frame");
    handshake(B0, "R6 first");

    // R10: rdFinish while idle does nothing
    handshake(B0, "R10 stray finish");

    // R7: starts 1..3 dropped, start 4 kept in other region
    sendFrame(1, 1'b0, B0, -1, 1'b0);
    sendFrame(2, 1'b0, B0, -1, 1'b0);
    sendFrame(3, 1'b0, B0, -1, 1'b0);
    sendFrame(4, 1'b1, B1, -1, 1'b0);
    expectWaiting("R5 continue after frame 4");

    // R8: kept slot 8 arrives while waiting and is dropped
    sendFrame(5, 1'b0, B0, -1, 1'b0);
    sendFrame(6, 1'b0, B0, -1, 1'b0);
    sendFrame(7, 1'b0, B0, -1, 1'b0);
    sendFrame(8, 1'b0, B0, -1, 1'b0);
    expectWaiting("R8 still waiting after slot 8");
    handshake(B1, "R6 second");
    sendFrame(9, 1'b0, B0, -1, 1'b0);
    sendFrame(10, 1'b0, B0, -1, 1'b0);
    sendFrame(11, 1'b0, B0, -1, 1'b0);
    // R9: stray first flag inside kept frame 12 written, not counted
    sendFrame(12, 1'b1, B0, 3, 1'b0);
    expectWaiting("R9 frame 12 completes");
    handshake(B0, "R6 third");
    sendFrame(13, 1'b0, B0, -1, 1'b0);
    sendFrame(14, 1'b0, B0, -1, 1'b0);
    sendFrame(15, 1'b0, B0, -1, 1'b0);
    sendFrame(16, 1'b1, B1, -1, 1'b0);
    expectWaiting("R9 count unaffected, frame 16 kept");

    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R4 all expected writes seen", 32'(expQ.size()), 32'h0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 20000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule